// File: doc/BRIEF.md
# Sixteen-Channel DAC Serial Register Bank

This block is the digital front of a multichannel digital-to-analog converter. A host drives it as a serial peripheral in mode 0 with an active-low chip select. Each transaction carries a 24-bit frame: an 8-bit command followed by a 16-bit data word, both most significant bit first. The block keeps two register stages per channel. The first stage is an input register that can be staged quietly. The second is a DAC register that drives the analog side. It also keeps the output span code and four dither configuration registers, and it can return any DAC register on the serial output.

The serial pins are brought into the system clock domain through synchronizers, and each frame takes effect when chip select is released. The DAC registers come out as one flat vector of parallel codes, one field per channel. The span and dither settings come out as plain vectors. A narrower variant keeps fewer code bits per channel. In that variant the code sits left-justified in the data word, in its upper bits.

Top module: `spi_dac_regbank`

## Requirements
- R1: After reset, every DAC and input register is zero, the span code is zero, the dither power-down vector is all ones, the invert, source and scale vectors are zero, and miso is low.
- R2: A frame acts only if exactly 24 rising sclk edges occur while cs_n is low, and then only when cs_n rises. A frame with any other bit count changes no register.
- R3: Command 0x1n loads data into input register n and leaves the DAC outputs unchanged. Command 0x2n loads data into DAC register n, which appears on dac_codes bits [n*CODE_BITS +: CODE_BITS].
- R4: Command 0x30 copies input register i into DAC register i for every set bit i of the data word. DAC registers whose bit is clear keep their value.
- R5: Command 0x60 loads the data word into every DAC register.
- R6: Command 0x40 loads data bits [2:0] into span_code.
- R7: Command 0x51 loads dither_pd, where a 1 powers down the dither of that channel. Command 0xB0 loads dither_inv, where a 1 inverts the dither of that channel.
- R8: Commands 0x90 and 0xA0 load bits [15:0] and [31:16] of dither_src. Commands 0xC0 and 0xD0 do the same for dither_scale. Each channel n owns bits [2n+1:2n]. A scale code of 0, 1, 2 or 3 selects a factor of 1, 0.75, 0.5 or 0.25.
- R9: Command 0x70 returns every register to its R1 state, but only when the data word is 0x1234. With any other data word it changes nothing.
- R10: Command 0x8n arms a readback of DAC register n. During the next frame, miso sends eight zeros and then the 16-bit left-justified value, most significant bit first. The value is taken when that frame's cs_n falls. Frames with no readback pending send all zeros.
- R11: Any command not listed above, including 0x00, changes no register.
- R12: With CODE_BITS below 16, DAC register n holds data bits [15 -: CODE_BITS]. A readback returns that code followed by zeros in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial readback data out |
| dac_codes | output | CHANNELS*CODE_BITS | DAC register of each channel, channel 0 in the low field |
| span_code | output | 3 | Output span selection |
| dither_pd | output | CHANNELS | Dither power-down, 1 = off |
| dither_inv | output | CHANNELS | Dither invert per channel |
| dither_src | output | 2*CHANNELS | Dither source, 2 bits per channel |
| dither_scale | output | 2*CHANNELS | Dither scale code, 2 bits per channel |

## Verification
Readback shift-out and a DAC write can land in the same frame. This happens when the frame that follows a readback command writes the channel being read, instead of carrying a no-op. The bench arms a readback of channel 5 and then sends a direct write of a new value to channel 5. It expects miso to carry the old value, because the value is captured when cs_n falls, and the parallel output to show the new value once cs_n rises. A second readback must then return the new value.

// File: rtl/spi_dac_regbank.sv
module spi_dac_regbank #(
  parameter int CHANNELS   = 16,
  parameter int CODE_BITS  = 16,
  parameter int FRAME_BITS = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk,
  input  logic                          cs_n,
  input  logic                          mosi,
  output logic                          miso,
  output logic [CHANNELS*CODE_BITS-1:0] dac_codes,
  output logic [2:0]                    span_code,
  output logic [CHANNELS-1:0]           dither_pd,
  output logic [CHANNELS-1:0]           dither_inv,
  output logic [2*CHANNELS-1:0]         dither_src,
  output logic [2*CHANNELS-1:0]         dither_scale
);
  localparam int WORD = 16;
  localparam int CW   = $clog2(FRAME_BITS + 2);
  localparam logic [WORD-1:0] UNLOCK = 16'h1234;

  logic [2:0] sclk_p, cs_p;
  logic [1:0] mosi_p;
  logic [FRAME_BITS-1:0] rx_sr, out_sr;
  logic [CW-1:0] bit_cnt;
  logic rb_armed;
  logic [3:0] rb_ch;

  logic [CODE_BITS-1:0] dac_q [CHANNELS];
  logic [CODE_BITS-1:0] in_q  [CHANNELS];
  logic [WORD-1:0]   pd_q, inv_q;
  logic [2*WORD-1:0] src_q, scl_q;
  logic [2:0]        span_q;

  logic sclk_rise, sclk_fall, cs_fall, cs_rise, active, frame_ok, key_hit, chan_ok;
  logic [7:0] cmd;
  logic [WORD-1:0] dat, rb_word;
  logic [3:0] chan;
  logic [CODE_BITS-1:0] code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end

  assign sclk_rise = sclk_p[1] & ~sclk_p[2];
  assign sclk_fall = ~sclk_p[1] & sclk_p[2];
  assign cs_fall   = ~cs_p[1] & cs_p[2];
  assign cs_rise   = cs_p[1] & ~cs_p[2];
  assign active    = ~cs_p[1];

  assign cmd      = rx_sr[FRAME_BITS-1 -: 8];
  assign dat      = rx_sr[WORD-1:0];
  assign chan     = cmd[3:0];
  assign chan_ok  = int'(chan) < CHANNELS;
  assign code     = dat[WORD-1 -: CODE_BITS];
  assign frame_ok = cs_rise && (bit_cnt == CW'(FRAME_BITS));
  assign key_hit  = frame_ok && cmd == 8'h70 && dat == UNLOCK;
  assign rb_word  = WORD'(dac_q[rb_ch]) << (WORD - CODE_BITS);
  assign miso     = active & out_sr[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sr   <= '0;
      out_sr  <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      out_sr  <= rb_armed ? FRAME_BITS'(rb_word) : '0;
    end else if (active && sclk_rise) begin
      rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_p[1]};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
    end else if (active && sclk_fall) begin
      out_sr <= {out_sr[FRAME_BITS-2:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rb_armed <= 1'b0;
      rb_ch    <= '0;
    end else if (cs_fall || key_hit) begin
      rb_armed <= 1'b0;
    end else if (frame_ok && cmd[7:4] == 4'h8 && chan_ok) begin
      rb_armed <= 1'b1;
      rb_ch    <= chan;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < CHANNELS; i++) begin
        dac_q[i] <= '0;
        in_q[i]  <= '0;
      end
      pd_q <= '1; inv_q <= '0; src_q <= '0; scl_q <= '0; span_q <= '0;
    end else if (key_hit) begin
      for (int i = 0; i < CHANNELS; i++) begin
        dac_q[i] <= '0;
        in_q[i]  <= '0;
      end
      pd_q <= '1; inv_q <= '0; src_q <= '0; scl_q <= '0; span_q <= '0;
    end else if (frame_ok) begin
      case (cmd[7:4])
        4'h1: if (chan_ok) in_q[chan] <= code;
        4'h2: if (chan_ok) dac_q[chan] <= code;
        4'h3: if (chan == 4'h0)
                for (int i = 0; i < CHANNELS; i++)
                  if (dat[i]) dac_q[i] <= in_q[i];
        4'h4: if (chan == 4'h0) span_q <= dat[2:0];
        4'h5: if (chan == 4'h1) pd_q <= dat;
        4'h6: if (chan == 4'h0)
                for (int i = 0; i < CHANNELS; i++) dac_q[i] <= code;
        4'h9: if (chan == 4'h0) src_q[WORD-1:0]    <= dat;
        4'hA: if (chan == 4'h0) src_q[2*WORD-1:WORD] <= dat;
        4'hB: if (chan == 4'h0) inv_q <= dat;
        4'hC: if (chan == 4'h0) scl_q[WORD-1:0]    <= dat;
        4'hD: if (chan == 4'h0) scl_q[2*WORD-1:WORD] <= dat;
        default: ;
      endcase
    end

  generate
    for (genvar g = 0; g < CHANNELS; g++) begin : g_out
      assign dac_codes[g*CODE_BITS +: CODE_BITS] = dac_q[g];
    end
  endgenerate

  assign span_code    = span_q;
  assign dither_pd    = pd_q[CHANNELS-1:0];
  assign dither_inv   = inv_q[CHANNELS-1:0];
  assign dither_src   = src_q[2*CHANNELS-1:0];
  assign dither_scale = scl_q[2*CHANNELS-1:0];

  assert_short_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != CW'(FRAME_BITS)) |=> $stable({dac_codes, span_code, dither_pd}));

  assert_input_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd[7:4] == 4'h1) |=> $stable(dac_codes));

  assert_masked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd == 8'h30 && dat[0]) |=> (dac_q[0] == $past(in_q[0])));

  assert_key_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (dither_pd == '1 && span_code == 3'd0 && dither_src == '0 && dac_codes == '0));

  assert_wrong_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd == 8'h70 && dat != UNLOCK) |=>
      $stable({dac_codes, span_code, dither_pd, dither_inv, dither_src, dither_scale}));

  assert_unknown_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd[7:4] == 4'hF) |=>
      $stable({dac_codes, span_code, dither_pd, dither_inv, dither_src, dither_scale}));
endmodule

// File: tb/spi_dac_regbank_bench.sv
module spi_dac_regbank_bench;
  localparam int CH = 16;
  localparam int NB = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_n;
  logic [CH*16-1:0] codes;
  logic [CH*NB-1:0] codes_n;
  logic [2:0] span, span_n;
  logic [CH-1:0] pd, inv, pd_n, inv_n;
  logic [2*CH-1:0] src, scl, src_n, scl_n;

  always #10 clk = ~clk;

  spi_dac_regbank u_spi_dac_regbank (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .dac_codes(codes), .span_code(span), .dither_pd(pd), .dither_inv(inv),
    .dither_src(src), .dither_scale(scl));

  spi_dac_regbank #(.CODE_BITS(NB)) u_narrow (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso_n),
    .dac_codes(codes_n), .span_code(span_n), .dither_pd(pd_n), .dither_inv(inv_n),
    .dither_src(src_n), .dither_scale(scl_n));

  int total = 0, bad = 0;
  logic [15:0] m_dac [CH];
  logic [15:0] m_in  [CH];
  logic [15:0] m_pd, m_inv;
  logic [31:0] m_src, m_scl;
  logic [2:0]  m_span;
  logic        m_armed;
  logic [3:0]  m_ch;

  logic [23:0] exp_q[$], got_q[$], expn_q[$], gotn_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < CH; i++) begin m_dac[i] = '0; m_in[i] = '0; end
    m_pd = '1; m_inv = '0; m_src = '0; m_scl = '0; m_span = '0; m_armed = 1'b0; m_ch = '0;
  endfunction

  function automatic void model_apply(logic [7:0] c, logic [15:0] d);
    logic [3:0] n = c[3:0];
    case (c[7:4])
      4'h1: m_in[n] = d;
      4'h2: m_dac[n] = d;
      4'h3: if (n == 0) for (int i = 0; i < CH; i++) if (d[i]) m_dac[i] = m_in[i];
      4'h4: if (n == 0) m_span = d[2:0];
      4'h5: if (n == 1) m_pd = d;
      4'h6: if (n == 0) for (int i = 0; i < CH; i++) m_dac[i] = d;
      4'h7: if (n == 0 && d == 16'h1234) model_reset();
      4'h8: begin m_armed = 1'b1; m_ch = n; end
      4'h9: if (n == 0) m_src[15:0] = d;
      4'hA: if (n == 0) m_src[31:16] = d;
      4'hB: if (n == 0) m_inv = d;
      4'hC: if (n == 0) m_scl[15:0] = d;
      4'hD: if (n == 0) m_scl[31:16] = d;
      default: ;
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] c, logic [15:0] d, int nbits = 24);
    logic [23:0] w = {c, d};
    logic [23:0] r = '0, rn = '0;
    logic [23:0] e  = m_armed ? {8'h00, m_dac[m_ch]} : 24'h0;
    logic [23:0] en = m_armed ? {8'h00, m_dac[m_ch] & 16'hFFF0} : 24'h0;
    m_armed = 1'b0;
    cs_n = 1'b0;
    tick(6);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[23-i];
      tick(6);
      r  = {r[22:0], miso};
      rn = {rn[22:0], miso_n};
      sclk = 1'b1;
      tick(6);
      sclk = 1'b0;
    end
    tick(6);
    cs_n = 1'b1;
    tick(10);
    if (nbits == 24) begin
      exp_q.push_back(e);  got_q.push_back(r);
      expn_q.push_back(en); gotn_q.push_back(rn);
      model_apply(c, d);
    end
  endtask

  initial forever begin
    wait (got_q.size() > 0);
    chk("R10 miso word", got_q.pop_front(), exp_q.pop_front());
    chk("R12 narrow miso word", gotn_q.pop_front(), expn_q.pop_front());
  end

  task automatic check_all(string tag);
    for (int i = 0; i < CH; i++) begin
      chk({tag, " dac"}, codes[i*16 +: 16], m_dac[i]);
      chk({tag, " R12 narrow dac"}, codes_n[i*NB +: NB], m_dac[i][15 -: NB]);
    end
    chk({tag, " span"}, span, m_span);
    chk({tag, " pd"}, pd, m_pd);
    chk({tag, " inv"}, inv, m_inv);
    chk({tag, " src"}, src, m_src);
    chk({tag, " scale"}, scl, m_scl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    tick(5);
    chk("R1 miso idle", miso, 1'b0);
    check_all("R1");
    rst_n = 1'b1;
    tick(5);

    frame(8'h23, 16'h1111);              check_all("R3 direct");
    frame(8'h10, 16'hA5A5);
    frame(8'h11, 16'h5A5A);
    frame(8'h17, 16'h7777);              check_all("R3 staged");
    frame(8'h30, 16'h0081);              check_all("R4 masked load");
    frame(8'h25, 16'hDEAD, 20);          check_all("R2 short frame");
    frame(8'h24, 16'h2468);              check_all("R2 recovery");
    frame(8'h60, 16'h4242);              check_all("R5 broadcast");
    frame(8'h22, 16'h0F0F);              check_all("R5 after broadcast");
    frame(8'h40, 16'hFFFD);              check_all("R6 span");
    frame(8'h51, 16'h00F0);
    frame(8'hB0, 16'h8001);              check_all("R7 pd/inv");
    frame(8'h90, 16'h1234);
    frame(8'hA0, 16'hABCD);
    frame(8'hC0, 16'h00FF);
    frame(8'hD0, 16'hFF00);              check_all("R8 src/scale");
    chk("R8 ch15 scale code", scl[31:30], 2'd3);
    frame(8'hF0, 16'hFFFF);
    frame(8'h52, 16'h0000);
    frame(8'h31, 16'hFFFF);
    frame(8'h00, 16'hFFFF);              check_all("R11 ignored");
    frame(8'h83, 16'h0000);
    frame(8'h00, 16'h0000);              check_all("R10 readback");
    frame(8'h85, 16'h0000);
    frame(8'h25, 16'hBEEF);              check_all("R10 overlap write");
    frame(8'h85, 16'h0000);
    frame(8'h00, 16'h0000);
    frame(8'h2A, 16'hABCD);
    frame(8'h8A, 16'h0000);
    frame(8'h00, 16'h0000);              check_all("R12 narrow");
    frame(8'h70, 16'h1235);              check_all("R9 wrong key");
    frame(8'h70, 16'h1234);              check_all("R9 key reset");
    chk("R9 pd all ones", pd, 16'hFFFF);
    frame(8'h00, 16'h0000);

    wait (got_q.size() == 0);
    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule